// File: doc/BRIEF.md
# Per-Core Power Domain Sequencer

This block powers individual processor cores up and down by walking each core's power controls through a fixed, ordered handshake. For each core it drives four lines: an isolation clamp, a power-switch request, a power-ready flag and an active-low power-on reset. After most steps it waits for the matching readback from the switch fabric before it moves to the next step. Every wait is bounded. If a readback does not arrive in time, the sequence stops with an error.

Commands arrive on a valid/ready port and name a core by cluster and position within the cluster. Only one core is sequenced at a time. A command offered while the block is busy is not held: it is refused and dropped. The cycle after a refused offer carries a one-cycle reject pulse, so the requester must offer the command again later. A boot-time trigger powers down the secondary cores one after another. That sweep covers the second cluster only when the cluster strap reports that the second cluster is present. A per-core status field reports off, on, in transition or failed.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every core is on: isolation 0, switch request 1, power-ready 1, reset line 1. Each status field reads on (code 1), the finger field is 0, busy is 0 and cmd_ready is 1.
- R2: A power-down raises isolation and waits for its readback. It then drops the switch request and waits for its readback, drops power-ready, and finally drives the reset line to 0 and waits for its readback. With immediate readbacks, done pulses 4 cycles after the accepting edge and the status becomes off (code 0).
- R3: A power-up raises the switch request and waits SETTLE cycles (clock MHz times 100 µs). It then raises power-ready, lowers isolation and returns the reset line to 1, waiting for the readback after each of those three steps. With immediate readbacks, done pulses SETTLE+3 cycles after acceptance and the status becomes on.
- R4: When finger_en is set at acceptance of a power-up, the 8-bit finger field is first set to 0xFC and an extra SETTLE-cycle wait is added, so done comes 2·SETTLE+3 cycles after acceptance.
- R5: Each readback wait allows up to 2000 samples. A match on the 2000th sample still advances the sequence. No match after 2000 samples gives an error pulse on the following cycle, and no later step is taken.
- R6: A failed core reports status error (code 3). The error is held until the next accepted command for that core, which sets the status to in transition (code 2).
- R7: The target core index is cluster × 2 + position within the cluster. Only that core's lines change.
- R8: cmd_ready is low while busy or while boot_go is high. A valid offer that is not ready is dropped and gives a one-cycle cmd_reject pulse on the next cycle. Only one core's lines change in any cycle.
- R9: boot_go while idle powers down core 1. If cluster_off is 0, it then also powers down cores 2 and 3, in that order. A single done pulse comes 4 cycles per core after the trigger edge.
- R10: An error during the boot sweep ends the sweep. The remaining cores are left untouched.
- R11: busy is high from the accepting edge until the sequence ends. done and error are single-cycle pulses and never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command will be accepted this cycle |
| cmd_up | input | 1 | 1 = power up, 0 = power down |
| cmd_cluster | input | 1 | Cluster number of the target core |
| cmd_local | input | 1 | Core position within the cluster |
| cmd_reject | output | 1 | Pulse: previous cycle's offer was dropped |
| boot_go | input | 1 | Start the secondary-core shutdown sweep |
| cluster_off | input | 1 | Strap: 1 = only the first cluster is present |
| finger_en | input | 1 | Program the finger field before a power-up |
| iso_rb | input | 4 | Isolation readback per core |
| req_rb | input | 4 | Switch-request readback per core |
| rdy_rb | input | 4 | Power-ready readback per core |
| por_rb | input | 4 | Reset-line readback per core |
| core_iso | output | 4 | Isolation clamp per core |
| core_pwr_req | output | 4 | Power-switch request per core |
| core_pwr_rdy | output | 4 | Power-ready per core |
| core_por_n | output | 4 | Active-low power-on reset per core |
| finger_code | output | 8 | Switch-finger field |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Pulse: sequence completed |
| error | output | 1 | Pulse: sequence aborted on timeout |
| core_status | output | 8 | Two bits per core, core 0 in bits 1:0 |

## Verification
Each result is due a fixed number of edges after the accepting edge:
- 4 edges for a power-down, or 4 per core for a boot sweep;
- SETTLE+3 edges for a power-up, or 2·SETTLE+3 with the finger field;
- exactly 2000 edges after the wait step is entered for a timeout error;
- one edge after a refused offer for a reject pulse.

The bench counts rising edges from acceptance and samples done, error and the core lines on the falling edge that follows each count. Every latency is therefore compared as an exact number. The boundary case releases a frozen readback in the 2000th sampled cycle, which must complete the sequence 3 edges later with no error.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    CST_OFF  = 2'd0,
    CST_ON   = 2'd1,
    CST_BUSY = 2'd2,
    CST_ERR  = 2'd3
  } cst_e;

  typedef enum logic [2:0] {
    RL_ISO  = 3'd0,
    RL_REQ  = 3'd1,
    RL_RDY  = 3'd2,
    RL_POR  = 3'd3,
    RL_NONE = 3'd4
  } rail_e;

  typedef enum logic [1:0] {
    WT_NONE   = 2'd0,
    WT_POLL   = 2'd1,
    WT_SETTLE = 2'd2
  } wait_e;

  typedef enum logic [3:0] {
    SP_IDLE   = 4'd0,
    SP_DN_ISO = 4'd1,
    SP_DN_REQ = 4'd2,
    SP_DN_RDY = 4'd3,
    SP_DN_POR = 4'd4,
    SP_UP_FNG = 4'd5,
    SP_UP_REQ = 4'd6,
    SP_UP_RDY = 4'd7,
    SP_UP_ISO = 4'd8,
    SP_UP_POR = 4'd9
  } step_e;

  typedef struct packed {
    rail_e rail;
    logic  level;
    wait_e wt;
    logic  last;
  } step_t;

  // Which line a step drives, to which level, and how it waits.
  function automatic step_t step_info(step_e s);
    step_t t;
    t.rail  = RL_NONE;
    t.level = 1'b0;
    t.wt    = WT_NONE;
    t.last  = 1'b0;
    case (s)
      SP_DN_ISO: begin t.rail = RL_ISO; t.level = 1'b1; t.wt = WT_POLL;   end
      SP_DN_REQ: begin t.rail = RL_REQ; t.level = 1'b0; t.wt = WT_POLL;   end
      SP_DN_RDY: begin t.rail = RL_RDY; t.level = 1'b0; t.wt = WT_NONE;   end
      SP_DN_POR: begin t.rail = RL_POR; t.level = 1'b0; t.wt = WT_POLL; t.last = 1'b1; end
      SP_UP_FNG: begin t.wt = WT_SETTLE; end
      SP_UP_REQ: begin t.rail = RL_REQ; t.level = 1'b1; t.wt = WT_SETTLE; end
      SP_UP_RDY: begin t.rail = RL_RDY; t.level = 1'b1; t.wt = WT_POLL;   end
      SP_UP_ISO: begin t.rail = RL_ISO; t.level = 1'b0; t.wt = WT_POLL;   end
      SP_UP_POR: begin t.rail = RL_POR; t.level = 1'b1; t.wt = WT_POLL; t.last = 1'b1; end
      default: ;
    endcase
    return t;
  endfunction

  function automatic step_e step_succ(step_e s);
    case (s)
      SP_DN_ISO: return SP_DN_REQ;
      SP_DN_REQ: return SP_DN_RDY;
      SP_DN_RDY: return SP_DN_POR;
      SP_UP_FNG: return SP_UP_REQ;
      SP_UP_REQ: return SP_UP_RDY;
      SP_UP_RDY: return SP_UP_ISO;
      SP_UP_ISO: return SP_UP_POR;
      default:   return SP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/cps_tick.sv
module cps_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cps_rails.sv
module cps_rails
  import cps_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int CIW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CIW-1:0]     wr_core,
  input  rail_e              wr_rail,
  input  logic               wr_lvl,
  input  logic               sa_en,
  input  logic [CIW-1:0]     sa_core,
  input  cst_e               sa_val,
  input  logic               sb_en,
  input  logic [CIW-1:0]     sb_core,
  input  cst_e               sb_val,
  output logic [NCORE-1:0]   iso,
  output logic [NCORE-1:0]   req,
  output logic [NCORE-1:0]   rdy,
  output logic [NCORE-1:0]   por_n,
  output logic [2*NCORE-1:0] status
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic hit_w, hit_a, hit_b;
    cst_e st_q;
    assign hit_w = wr_en && (wr_core == CIW'(c));
    assign hit_a = sa_en && (sa_core == CIW'(c));
    assign hit_b = sb_en && (sb_core == CIW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iso[c]   <= 1'b0;
        req[c]   <= 1'b1;
        rdy[c]   <= 1'b1;
        por_n[c] <= 1'b1;
      end else if (hit_w) begin
        case (wr_rail)
          RL_ISO: iso[c]   <= wr_lvl;
          RL_REQ: req[c]   <= wr_lvl;
          RL_RDY: rdy[c]   <= wr_lvl;
          RL_POR: por_n[c] <= wr_lvl;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= CST_ON;
      else if (hit_b) st_q <= sb_val;
      else if (hit_a) st_q <= sa_val;
    end
    assign status[2*c +: 2] = st_q;
  end
endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int          NCORE      = 4,
  parameter int          CPC        = 2,
  parameter int          POLL_LIMIT = 2000,
  parameter int          SETTLE_CYC = 100,
  parameter int          CW         = 12,
  parameter int          CIW        = 2,
  parameter logic [7:0]  FNG_VAL    = 8'hFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_cmd,
  input  logic             go_up,
  input  logic [CIW-1:0]   go_core,
  input  logic             go_boot,
  input  logic             fng_mode,
  input  logic             cluster_off,
  input  logic [NCORE-1:0] iso_rb,
  input  logic [NCORE-1:0] req_rb,
  input  logic [NCORE-1:0] rdy_rb,
  input  logic [NCORE-1:0] por_rb,
  input  logic [CW-1:0]    cnt,
  output logic             cnt_clr,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [7:0]       finger,
  output logic             wr_en,
  output logic [CIW-1:0]   wr_core,
  output rail_e            wr_rail,
  output logic             wr_lvl,
  output logic             sa_en,
  output logic [CIW-1:0]   sa_core,
  output cst_e             sa_val,
  output logic             sb_en,
  output logic [CIW-1:0]   sb_core,
  output cst_e             sb_val
);
  localparam int SWEEP_FIRST = 1;

  step_e          step_q, step_n;
  logic [CIW-1:0] core_q, core_n;
  logic           up_q, boot_q;
  step_t          cur, nxt;
  logic           rb_bit, poll_end, settle_end;
  logic           adv, fail, enter, start_core, more;

  assign cur        = step_info(step_q);
  assign nxt        = step_info(step_n);
  assign poll_end   = (cnt == CW'(POLL_LIMIT - 1));
  assign settle_end = (cnt == CW'(SETTLE_CYC - 1));
  assign busy       = (step_q != SP_IDLE);
  assign more       = boot_q && ((int'(core_q) + 1) < (cluster_off ? CPC : NCORE));

  always_comb begin
    case (cur.rail)
      RL_ISO:  rb_bit = iso_rb[core_q];
      RL_REQ:  rb_bit = req_rb[core_q];
      RL_RDY:  rb_bit = rdy_rb[core_q];
      RL_POR:  rb_bit = por_rb[core_q];
      default: rb_bit = 1'b0;
    endcase
  end

  always_comb begin
    adv  = 1'b0;
    fail = 1'b0;
    if (busy) begin
      case (cur.wt)
        WT_NONE:   adv = 1'b1;
        WT_POLL:   begin
          if (rb_bit == cur.level) adv  = 1'b1;
          else if (poll_end)       fail = 1'b1;
        end
        WT_SETTLE: adv = settle_end;
        default: ;
      endcase
    end
  end

  always_comb begin
    step_n     = step_q;
    core_n     = core_q;
    enter      = 1'b0;
    start_core = 1'b0;
    if (!busy) begin
      if (go_boot) begin
        step_n = SP_DN_ISO; core_n = CIW'(SWEEP_FIRST);
        enter = 1'b1; start_core = 1'b1;
      end else if (go_cmd) begin
        core_n = go_core;
        step_n = go_up ? (fng_mode ? SP_UP_FNG : SP_UP_REQ) : SP_DN_ISO;
        enter = 1'b1; start_core = 1'b1;
      end
    end else if (fail) begin
      step_n = SP_IDLE;
    end else if (adv) begin
      if (cur.last) begin
        if (more) begin
          core_n = core_q + 1'b1; step_n = SP_DN_ISO;
          enter = 1'b1; start_core = 1'b1;
        end else begin
          step_n = SP_IDLE;
        end
      end else begin
        step_n = step_succ(step_q);
        enter  = 1'b1;
      end
    end
  end

  assign cnt_clr = (step_n != step_q) || !busy;

  // Line writes take effect at the edge that enters the step.
  assign wr_en   = enter && (nxt.rail != RL_NONE);
  assign wr_core = core_n;
  assign wr_rail = nxt.rail;
  assign wr_lvl  = nxt.level;

  // Port A closes out the current core; port B opens the next one.
  assign sa_en   = fail || (adv && cur.last);
  assign sa_core = core_q;
  assign sa_val  = fail ? CST_ERR : (up_q ? CST_ON : CST_OFF);
  assign sb_en   = start_core;
  assign sb_core = core_n;
  assign sb_val  = CST_BUSY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= SP_IDLE;
      core_q <= '0;
      up_q   <= 1'b0;
      boot_q <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
      finger <= '0;
    end else begin
      step_q <= step_n;
      core_q <= core_n;
      done   <= adv && cur.last && !more && !fail;
      error  <= fail;
      if (!busy && (go_boot || go_cmd)) begin
        up_q   <= go_boot ? 1'b0 : go_up;
        boot_q <= go_boot;
      end
      if (enter && step_n == SP_UP_FNG) finger <= FNG_VAL;
    end
  end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int         NCORE      = 4,
  parameter int         CPC        = 2,
  parameter int         POLL_LIMIT = 2000,
  parameter int         CLK_MHZ    = 1000,
  parameter int         SETTLE_US  = 100,
  parameter logic [7:0] FNG_VAL    = 8'hFC,
  localparam int        NCLUS      = NCORE / CPC,
  localparam int        CLW        = (NCLUS > 1) ? $clog2(NCLUS) : 1,
  localparam int        LW         = (CPC > 1) ? $clog2(CPC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_up,
  input  logic [CLW-1:0]     cmd_cluster,
  input  logic [LW-1:0]      cmd_local,
  output logic               cmd_reject,
  input  logic               boot_go,
  input  logic               cluster_off,
  input  logic               finger_en,
  input  logic [NCORE-1:0]   iso_rb,
  input  logic [NCORE-1:0]   req_rb,
  input  logic [NCORE-1:0]   rdy_rb,
  input  logic [NCORE-1:0]   por_rb,
  output logic [NCORE-1:0]   core_iso,
  output logic [NCORE-1:0]   core_pwr_req,
  output logic [NCORE-1:0]   core_pwr_rdy,
  output logic [NCORE-1:0]   core_por_n,
  output logic [7:0]         finger_code,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [2*NCORE-1:0] core_status
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int MAXC       = (SETTLE_CYC > POLL_LIMIT) ? SETTLE_CYC : POLL_LIMIT;
  localparam int CW         = $clog2(MAXC + 1);
  localparam int CIW        = (NCORE > 1) ? $clog2(NCORE) : 1;

  logic           go_cmd, go_boot, cnt_clr;
  logic [CIW-1:0] go_core;
  logic [CW-1:0]  cnt;
  logic           wr_en, wr_lvl, sa_en, sb_en;
  logic [CIW-1:0] wr_core, sa_core, sb_core;
  rail_e          wr_rail;
  cst_e           sa_val, sb_val;

  assign cmd_ready = !busy && !boot_go;
  assign go_cmd    = cmd_valid && cmd_ready;
  assign go_boot   = boot_go && !busy;
  assign go_core   = CIW'(int'(cmd_cluster) * CPC + int'(cmd_local));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_reject <= 1'b0;
    else        cmd_reject <= cmd_valid && !cmd_ready;
  end

  cps_tick #(.CW(CW)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
  );

  cps_ctrl #(
    .NCORE(NCORE), .CPC(CPC), .POLL_LIMIT(POLL_LIMIT), .SETTLE_CYC(SETTLE_CYC),
    .CW(CW), .CIW(CIW), .FNG_VAL(FNG_VAL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd), .go_up(cmd_up), .go_core(go_core),
    .go_boot(go_boot), .fng_mode(finger_en), .cluster_off(cluster_off),
    .iso_rb(iso_rb), .req_rb(req_rb), .rdy_rb(rdy_rb), .por_rb(por_rb),
    .cnt(cnt), .cnt_clr(cnt_clr), .busy(busy), .done(done), .error(error),
    .finger(finger_code), .wr_en(wr_en), .wr_core(wr_core), .wr_rail(wr_rail),
    .wr_lvl(wr_lvl), .sa_en(sa_en), .sa_core(sa_core), .sa_val(sa_val),
    .sb_en(sb_en), .sb_core(sb_core), .sb_val(sb_val)
  );

  cps_rails #(.NCORE(NCORE), .CIW(CIW)) u_rails (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_core(wr_core), .wr_rail(wr_rail),
    .wr_lvl(wr_lvl), .sa_en(sa_en), .sa_core(sa_core), .sa_val(sa_val),
    .sb_en(sb_en), .sb_core(sb_core), .sb_val(sb_val),
    .iso(core_iso), .req(core_pwr_req), .rdy(core_pwr_rdy), .por_n(core_por_n),
    .status(core_status)
  );
endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int NCORE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_reject,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic [NCORE-1:0] core_iso,
  input logic [NCORE-1:0] core_pwr_req,
  input logic [NCORE-1:0] core_pwr_rdy,
  input logic [NCORE-1:0] core_por_n
);
  // R8
  reject_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_reject);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R2
  req_drop_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~core_pwr_req & $past(core_pwr_req) & ~core_iso) == '0));

  // R2
  por_assert_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~core_por_n & $past(core_por_n) & core_pwr_req) == '0));

  // R3
  iso_release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~core_iso & $past(core_iso) & ~core_pwr_rdy) == '0));

  // R3
  por_release_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_por_n & ~$past(core_por_n) & core_iso) == '0));

  // R8
  one_core_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0((core_iso ^ $past(core_iso)) | (core_pwr_req ^ $past(core_pwr_req)) |
             (core_pwr_rdy ^ $past(core_pwr_rdy)) | (core_por_n ^ $past(core_por_n))));
endmodule

bind core_pwr_seq cps_chk #(.NCORE(NCORE)) u_cps_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_reject(cmd_reject), .busy(busy), .done(done), .error(error),
  .core_iso(core_iso), .core_pwr_req(core_pwr_req), .core_pwr_rdy(core_pwr_rdy),
  .core_por_n(core_por_n)
);

// File: tb/test_core_pwr_seq.sv
module test_core_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 100;
  localparam int POLL       = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_up = 1'b0, cmd_cluster = 1'b0, cmd_local = 1'b0;
  logic       boot_go = 1'b0, cluster_off = 1'b0, finger_en = 1'b0;
  logic       cmd_ready, cmd_reject, busy, done, error;
  logic [3:0] iso_rb, req_rb, rdy_rb, por_rb, iso_fz = 4'b0;
  logic [3:0] core_iso, core_pwr_req, core_pwr_rdy, core_por_n;
  logic [7:0] finger_code, core_status;
  int         total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Switch fabric model: readbacks follow the lines, isolation can be frozen low.
  assign iso_rb = core_iso & ~iso_fz;
  assign req_rb = core_pwr_req;
  assign rdy_rb = core_pwr_rdy;
  assign por_rb = core_por_n;

  core_pwr_seq #(.CLK_MHZ(1), .SETTLE_US(100), .POLL_LIMIT(POLL)) i_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_up(cmd_up), .cmd_cluster(cmd_cluster), .cmd_local(cmd_local),
    .cmd_reject(cmd_reject), .boot_go(boot_go), .cluster_off(cluster_off),
    .finger_en(finger_en), .iso_rb(iso_rb), .req_rb(req_rb), .rdy_rb(rdy_rb),
    .por_rb(por_rb), .core_iso(core_iso), .core_pwr_req(core_pwr_req),
    .core_pwr_rdy(core_pwr_rdy), .core_por_n(core_por_n), .finger_code(finger_code),
    .busy(busy), .done(done), .error(error), .core_status(core_status)
  );

  function automatic logic [7:0] st(input int s0, input int s1, input int s2, input int s3);
    return {s3[1:0], s2[1:0], s1[1:0], s0[1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Offer one command; returns on the falling edge after the accepting edge.
  task automatic send(input logic up, input logic cl, input logic lo);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_up = up; cmd_cluster = cl; cmd_local = lo;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic boot(input logic single);
    @(negedge clk);
    cluster_off = single; boot_go = 1'b1;
    @(negedge clk);
    boot_go = 1'b0;
  endtask

  // Counts rising edges after acceptance until done or error is seen.
  task automatic wait_end(input int rel_at, output int k);
    k = 0;
    while (!done && !error && k < 6000) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (k == rel_at) iso_fz = 4'b0;
    end
  endtask

  task automatic t_reset();
    chk_eq("R1 iso", core_iso, 0);
    chk_eq("R1 req", core_pwr_req, 4'hF);
    chk_eq("R1 rdy", core_pwr_rdy, 4'hF);
    chk_eq("R1 por", core_por_n, 4'hF);
    chk_eq("R1 status", core_status, st(1, 1, 1, 1));
    chk_eq("R1 finger", finger_code, 0);
    chk_eq("R1 busy/ready", {busy, cmd_ready}, 2'b01);
  endtask

  task automatic t_boot_single();
    int k;
    boot(1'b1);
    wait_end(-1, k);
    chk_eq("R9 single-cluster latency", k, 4);
    chk_eq("R9 single-cluster status", core_status, st(1, 0, 1, 1));
    chk_eq("R2 core1 lines iso/req/rdy/por",
           {core_iso[1], core_pwr_req[1], core_pwr_rdy[1], core_por_n[1]}, 4'b1000);
    @(negedge clk);
    chk_eq("R11 done single pulse", done, 0);
  endtask

  task automatic t_up(input logic cl, input logic lo, input logic fng, input int exp_k,
                      input logic [7:0] exp_st, input string req);
    int k;
    finger_en = fng;
    send(1'b1, cl, lo);
    chk_eq("R11 busy during sequence", busy, 1);
    wait_end(-1, k);
    finger_en = 1'b0;
    chk_eq({req, " latency"}, k, exp_k);
    chk_eq({req, " status"}, core_status, exp_st);
  endtask

  task automatic t_boot_dual();
    int k;
    boot(1'b0);
    wait_end(-1, k);
    chk_eq("R9 dual-cluster latency", k, 12);
    chk_eq("R9 dual-cluster status", core_status, st(1, 0, 0, 0));
    chk_eq("R9 dual-cluster por", core_por_n, 4'b0001);
  endtask

  task automatic t_reject();
    int k;
    send(1'b0, 1'b0, 1'b0);
    cmd_valid = 1'b1; cmd_up = 1'b0; cmd_cluster = 1'b1; cmd_local = 1'b1;
    chk_eq("R8 ready low while busy", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_eq("R8 reject pulse", cmd_reject, 1);
    @(negedge clk);
    chk_eq("R8 reject one cycle", cmd_reject, 0);
    wait_end(-1, k);
    chk_eq("R8 dropped command had no effect", core_status, st(0, 1, 1, 1));
    chk_eq("R8 core3 lines untouched", {core_iso[3], core_por_n[3]}, 2'b01);
  endtask

  task automatic t_poll_edge();
    int k;
    iso_fz = 4'b1000;
    send(1'b0, 1'b1, 1'b1);
    wait_end(POLL - 1, k);
    chk_eq("R5 readback on last sample accepted", k, POLL + 3);
    chk_eq("R5 no error at boundary", error, 0);
    chk_eq("R5 boundary status", core_status, st(1, 1, 1, 0));
  endtask

  task automatic t_timeout();
    int k;
    iso_fz = 4'b0100;
    send(1'b0, 1'b1, 1'b0);
    wait_end(-1, k);
    chk_eq("R5 timeout latency", k, POLL);
    chk_eq("R5 error pulse", {error, done}, 2'b10);
    chk_eq("R5 later steps not taken", {core_pwr_req[2], core_pwr_rdy[2], core_por_n[2]}, 3'b111);
    repeat (5) @(negedge clk);
    chk_eq("R6 error status held", core_status[5:4], 3);
    iso_fz = 4'b0;
    send(1'b1, 1'b1, 1'b0);
    chk_eq("R6 next command sets transition", core_status[5:4], 2);
    wait_end(-1, k);
    chk_eq("R6 recovered status", core_status[5:4], 1);
  endtask

  task automatic t_boot_abort();
    int k;
    iso_fz = 4'b0100;
    boot(1'b0);
    wait_end(-1, k);
    iso_fz = 4'b0;
    chk_eq("R10 abort latency", k, 4 + POLL);
    chk_eq("R10 sweep stopped", core_status, st(1, 0, 3, 1));
    chk_eq("R10 core3 untouched", {core_iso[3], core_pwr_req[3], core_por_n[3]}, 3'b011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boot_single();
    t_up(1'b0, 1'b1, 1'b0, SETTLE + 3, st(1, 1, 1, 1), "R3 up core1");
    t_boot_dual();
    // R7: cluster 1, position 0 selects core 2 only
    t_up(1'b1, 1'b0, 1'b1, 2 * SETTLE + 3, st(1, 0, 1, 0), "R4 finger up core2");
    chk_eq("R4 finger field", finger_code, 8'hFC);
    chk_eq("R7 only core2 released", core_iso, 4'b1010);
    t_up(1'b1, 1'b1, 1'b0, SETTLE + 3, st(1, 0, 1, 1), "R7 up core3");
    t_up(1'b0, 1'b1, 1'b0, SETTLE + 3, st(1, 1, 1, 1), "R3 up core1 again");
    t_reject();
    t_up(1'b0, 1'b0, 1'b0, SETTLE + 3, st(1, 1, 1, 1), "R3 up core0");
    t_poll_edge();
    t_up(1'b1, 1'b1, 1'b0, SETTLE + 3, st(1, 1, 1, 1), "R3 up core3 again");
    t_timeout();
    t_boot_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule